// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a hardware watchdog. An 8-bit down-counter is loaded by software and steps down once per prescale period of the system clock. One clock after the counter reaches 1, a sticky non-maskable interrupt output rises. This warns the processor that expiry is near. When the counter reaches 0, a one-cycle chip reset pulse fires and the watchdog falls back to the stopped state.

Software controls the block with a single write of a control word. The word holds a reload count, a command bit (start or stop) and a 7-bit key. The block keeps the last accepted key. A write counts only if its key is the bitwise inverse of that stored key, so a runaway program that repeats one write cannot keep the watchdog alive. A start issued while the watchdog is running reloads the counter, which is how software kicks it. Stopping the watchdog needs a valid key just as starting it does.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, status, nmi and chip_reset are 0 and the stored key equals parameter KEY_INIT (default 0x2A), so the first write that counts must carry key 0x55.
- R2: The control word is laid out as count in bits [7:0], command in bit 8 (1 = start, 0 = stop) and key in bits [15:9].
- R3: A write is accepted exactly when its key equals the stored key XOR 0x7F, and the accepted key then becomes the stored key.
- R4: A write with any other key has no effect: status, the counter, the expiry timing and the stored key all stay unchanged.
- R5: An accepted start loads the count, sets status to 1 and clears the prescaler, so the first decrement happens PRESCALE clocks after the write edge.
- R6: While running, the counter decrements once every PRESCALE clocks and holds otherwise.
- R7: nmi rises one clock after the counter holds the value 1 while running, and it stays high until the next accepted write, even after expiry.
- R8: When a decrement takes the counter from 1, or a tick arrives with the counter at 0, chip_reset is high for exactly one cycle and status drops to 0 at the same edge. A start with count 0 therefore expires after one prescale period.
- R9: An accepted start while running reloads the counter and restarts the prescale period, which delays expiry.
- R10: An accepted stop clears status and nmi, and no chip_reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: key, command, count |
| nmi | output | 1 | Sticky pre-expiry warning |
| chip_reset | output | 1 | One-cycle expiry pulse |
| status | output | 1 | 1 while the watchdog is running |

## Verification
The bench sweeps every start count from 0 to 40 plus 255 with a short prescale period. At each start it compares all three outputs cycle by cycle against arithmetic expiry and warning times, so an off-by-one prescaler, a missing warning for count 1, or an underflow on count 0 would show as a shifted or absent edge. It also sends writes with wrong keys, both while running and while stopped. A design that let a wrong key through would stop early, or would shift the key sequence so that a later valid write failed. Kicks and valid stops are placed mid-count, after nmi has risen, to catch a reload that does not restart the prescaler or a stop that leaves nmi set.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } wdk_cmd_e;
endpackage

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
    parameter int PRESCALE = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.phase = '0;
        end else if (run) begin
            if (st_q.phase == LAST) begin
                st_d.phase = '0;
                tick       = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
    assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= LAST);
endmodule

// File: rtl/wdk_keygate.sv
module wdk_keygate #(
    parameter int          KEY_W    = 7,
    parameter logic [KEY_W-1:0] KEY_INIT = 7'h2A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = wr_en && (wr_key == (st_q.key ^ {KEY_W{1'b1}}));
        if (accept) st_d.key = wr_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.key <= KEY_INIT;
        else        st_q     <= st_d;
    end

    assert_key_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st_q.key));
    assert_key_inverts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.key == ($past(st_q.key) ^ {KEY_W{1'b1}})));
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_start,
    input  logic             do_stop,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             running,
    output logic             nmi,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             nmi;
        logic             fire;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (do_start) begin
            st_d.count   = load_val;
            st_d.running = 1'b1;
            st_d.nmi     = 1'b0;
        end else if (do_stop) begin
            st_d.running = 1'b0;
            st_d.nmi     = 1'b0;
        end else begin
            if (st_q.running && st_q.count == ONE) st_d.nmi = 1'b1;
            if (st_q.running && tick) begin
                if (st_q.count <= ONE) begin
                    st_d.count   = '0;
                    st_d.running = 1'b0;
                    st_d.fire    = 1'b1;
                end else begin
                    st_d.count = st_q.count - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.running;
    assign nmi     = st_q.nmi;
    assign fire    = st_q.fire;

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |=> !st_q.fire);
    assert_fire_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> !st_q.running);
    assert_nmi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nmi) |-> ($past(st_q.count) == ONE && $past(st_q.running)));
    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !do_start) |=> $stable(st_q.count));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int               CNT_W    = 8,
    parameter int               KEY_W    = 7,
    parameter int               PRESCALE = 131072,
    parameter logic [KEY_W-1:0] KEY_INIT = 7'h2A,
    localparam int              WORD_W   = CNT_W + 1 + KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              nmi,
    output logic              chip_reset,
    output logic              status
);
    import wdk_pkg::*;

    localparam int CMD_BIT = CNT_W;
    localparam int KEY_LO  = CNT_W + 1;

    logic [CNT_W-1:0] f_count;
    wdk_cmd_e         f_cmd;
    logic [KEY_W-1:0] f_key;
    logic             accept, do_start, do_stop, tick, running;

    assign f_count  = wr_data[CNT_W-1:0];
    assign f_cmd    = wdk_cmd_e'(wr_data[CMD_BIT]);
    assign f_key    = wr_data[WORD_W-1:KEY_LO];
    assign do_start = accept && (f_cmd == CMD_START);
    assign do_stop  = accept && (f_cmd == CMD_STOP);

    wdk_keygate #(.KEY_W(KEY_W), .KEY_INIT(KEY_INIT)) u_keygate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(f_key), .accept(accept)
    );

    wdk_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk(clk), .rst_n(rst_n), .run(running), .clear(do_start || do_stop), .tick(tick)
    );

    wdk_countdown #(.CNT_W(CNT_W)) u_countdown (
        .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_stop(do_stop),
        .load_val(f_count), .tick(tick), .running(running), .nmi(nmi), .fire(chip_reset)
    );

    assign status = running;

    assert_reject_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !running) |=> !status);
    assert_start_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_start |=> (status && !nmi && !chip_reset));
    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_stop |=> (!status && !nmi && !chip_reset));
endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        nmi, chip_reset, status;

    int compared = 0;
    int mismatched = 0;
    logic [6:0] exp_key = 7'h2A;

    always #2 clk = ~clk;

    keyed_watchdog #(.PRESCALE(P)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .nmi(nmi), .chip_reset(chip_reset), .status(status)
    );

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // R2 layout: {key[15:9], cmd[8], count[7:0]}; good=1 uses the inverted key (R3)
    task automatic wr(int cnt, bit start, bit good);
        logic [6:0] k;
        k = exp_key ^ 7'h7F;
        if (!good) k = k ^ 7'h01;
        else exp_key = k;
        wr_en   = 1'b1;
        wr_data = {k, start, cnt[7:0]};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // kind: 0 none, 1 bad-key stop (R4), 2 kick (R9), 3 valid stop (R10), at edge m
    task automatic run_case(int n, int m, int kind, int n2, string tag);
        int base = 0;
        int nc = n;
        bit halted = 0;
        int k = 0;
        int x, lim, kr;
        wr(n, 1'b1, 1'b1);
        forever begin
            x   = P * ((nc == 0) ? 1 : nc);
            lim = halted ? m + 20 : base + x + 2;
            if (k > lim) break;
            kr = k - base;
            if (halted) begin
                chk({tag, " status R10"}, status, 0);
                chk({tag, " nmi R10"}, nmi, 0);
                chk({tag, " chip_reset R10"}, chip_reset, 0);
            end else begin
                chk({tag, " status R5 R6"}, status, (kr < x) ? 1 : 0);
                chk({tag, " chip_reset R8"}, chip_reset, (kr == x) ? 1 : 0);
                chk({tag, " nmi R7"}, nmi, (nc >= 1 && kr >= P * (nc - 1) + 1) ? 1 : 0);
            end
            if (kind != 0 && k + 1 == m) begin
                case (kind)
                    1: wr(0, 1'b0, 1'b0);
                    2: begin wr(n2, 1'b1, 1'b1); base = m; nc = n2; end
                    default: begin wr(0, 1'b0, 1'b1); halted = 1; end
                endcase
            end else begin
                @(negedge clk);
            end
            k++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset status R1", status, 0);
        chk("reset nmi R1", nmi, 0);
        chk("reset chip_reset R1", chip_reset, 0);

        // R4: wrong key while stopped must not start, and must not move the key
        wr(5, 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) begin
            chk("bad key stopped status R4", status, 0);
            chk("bad key stopped chip_reset R4", chip_reset, 0);
            @(negedge clk);
        end

        // R1 R3: first valid key is 0x55; sweep of counts R5 R6 R7 R8
        for (int n = 0; n <= 40; n++) run_case(n, 0, 0, 0, "sweep");
        run_case(255, 0, 0, 0, "sweep255");

        run_case(3, 5, 1, 0, "badstop R4");
        run_case(3, 6, 2, 3, "kick R9");
        run_case(2, 7, 2, 1, "kick after nmi R9");
        run_case(5, 3, 3, 0, "stop R10");
        run_case(2, 7, 3, 0, "stop after nmi R10");
        run_case(1, 0, 0, 0, "after stops R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule